// File: doc/BRIEF.md
# Frame-Aligned Cascadable Serializer

This block turns a parallel word of up to ten bits into a serial stream on a fast bit clock. A slower frame reference marks each word boundary. The block samples that reference in the bit-clock domain. The first bit-clock edge after the reference goes high captures the parallel word. The bits then leave least significant first, one per bit-clock edge, with bit 0 placed on the third edge after the reference edge. A frame clock output rises on that first edge, so a receiver can line up each word.

The multiplex ratio M is a static input with a binary value from 2 to 64. For ratios of ten or less, only the low M parallel bits are sent. For larger ratios, all ten local bits go out first. The remaining bit times are filled from a cascade serial input, which is wired to the serial output of the previous stage in a chain. Three enables control the block:
- the main enable turns off the whole block;
- the frame-clock enable turns off only the frame clock;
- the cascade enable forces the cascade input to zero.

The off state of each output is reported on a separate valid flag.

Top module: `frame_serializer`

## Requirements
- R1: The parallel word is captured on the first bit-clock rising edge at which the frame reference is high and was low at the previous edge. Later changes of the parallel inputs do not affect that frame.
- R2: Parallel bit 0 is on the serial output after the third rising edge, counting the capture edge as the first. The serial output changes only on rising edges.
- R3: The following bits come out in ascending index order, one per rising edge, so each frame carries exactly M bit times. A frame starts every M cycles.
- R4: The frame clock output goes high on the capture edge and stays high for floor(M/2) cycles. It then stays low until the next capture edge.
- R5: When M is 10 or less, only parallel bits 0 to M-1 are sent and the cascade input has no effect on the serial output.
- R6: When M is above 10, bit times 10 to M-1 carry cascade data. The value on the cascade input during the cycle after edge 3+u appears on the serial output after edge 13+u. This is exactly the slot of bit 10+u.
- R7: While the main enable is low, both valid flags are 0, both outputs are 0 and all frame state is cleared. After re-enabling, the block behaves as it does after reset.
- R8: While the frame-clock enable is low, the frame clock output and its valid flag are 0. Serial data is unaffected.
- R9: While the cascade enable is low, the cascade input reads as 0. Bit times 10 and above then carry 0.
- R10: After the synchronous active-high reset, the serial output and the frame clock output stay 0 until the first frame reference edge. This holds whatever the cascade input does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Main enable; low disables the block |
| frameClkEn | input | 1 | Frame clock output enable |
| cascadeEn | input | 1 | Cascade input enable |
| ratio | input | 7 | Multiplex ratio M, binary, 2 to 64 |
| frameRef | input | 1 | Frame reference; its rising edge marks a word boundary |
| parIn | input | 10 | Parallel data word |
| cascadeIn | input | 1 | Serial data from the preceding stage |
| serOut | output | 1 | Serial data output |
| serValid | output | 1 | Serial output is driven (not high impedance) |
| frameClkOut | output | 1 | Frame clock output |
| frameClkValid | output | 1 | Frame clock output is driven |

## Verification
Each frame is counted in edges from the capture edge E1, the first rising edge after the reference goes high:
- The frame clock is due after E1.
- Bit k is due after edge E(3+k).
- A cascade value presented after E(3+u) is due after E(13+u).

The bench changes inputs and samples outputs on falling edges. It therefore reads the value each edge produced and compares it with an expected value built from the word, the cascade pattern and M. The last two bits of a frame fall into the first two cycles of the next frame. They are checked there against the word of the frame before.

// File: rtl/fser_pkg.sv
package fser_pkg;

  // Strobes from the frame controller to the shift datapath
  typedef struct packed {
    logic latchWord;  // capture parallel word this edge
    logic loadShift;  // move captured word into the shifter this edge
    logic shiftOn;    // shifter runs (first frame seen)
    logic useCasc;    // cascade data feeds the shifter
  } serStrobes_t;

endpackage

// File: rtl/fser_ctrl.sv
module fser_ctrl
  import fser_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int RATIO_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               frameRef,
  input  logic               cascadeEn,
  input  logic [RATIO_W-1:0] ratio,
  output serStrobes_t        strb,
  output logic               frameClk
);

  localparam logic [RATIO_W-1:0] CNT_MAX = '1;

  logic               clr;
  logic               refPrev;
  logic               refRise;
  logic               pend1, pend2;
  logic               started;
  logic [RATIO_W-1:0] frameCnt;
  logic [RATIO_W-1:0] halfM;
  logic               fclkQ;

  assign clr     = rst | ~enable;
  assign refRise = enable & frameRef & ~refPrev;
  assign halfM   = ratio >> 1;

  always_ff @(posedge clk) begin
    if (clr) begin
      refPrev  <= 1'b0;
      pend1    <= 1'b0;
      pend2    <= 1'b0;
      started  <= 1'b0;
      frameCnt <= '0;
      fclkQ    <= 1'b0;
    end else begin
      refPrev <= frameRef;
      pend1   <= refRise;
      pend2   <= pend1;
      started <= started | refRise;
      if (refRise) begin
        frameCnt <= RATIO_W'(1);
        fclkQ    <= 1'b1;
      end else begin
        if (frameCnt != CNT_MAX) frameCnt <= frameCnt + 1'b1;
        fclkQ <= fclkQ & (frameCnt < halfM);
      end
    end
  end

  always_comb begin
    strb.latchWord = refRise;
    strb.loadShift = pend2;
    strb.shiftOn   = started;
    strb.useCasc   = cascadeEn & (ratio > RATIO_W'(WORD_W));
  end

  assign frameClk = fclkQ;

  // R4: a rising frame clock always coincides with a capture one edge earlier
  a_r4_fclk_aligned: assert property (@(posedge clk) disable iff (rst)
    $rose(fclkQ) |-> pend1);

  // R3: the shifter load follows a capture by exactly two edges
  a_r3_load_spacing: assert property (@(posedge clk) disable iff (rst)
    (pend2 && enable) |-> $past(refRise, 2));

endmodule

// File: rtl/fser_datapath.sv
module fser_datapath
  import fser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  serStrobes_t       strb,
  input  logic [WORD_W-1:0] parIn,
  input  logic              cascadeIn,
  output logic              serBit
);

  logic              clr;
  logic [WORD_W-1:0] holdWord;
  logic [WORD_W-1:0] shiftReg;
  logic              cascBit;

  assign clr     = rst | ~enable;
  assign cascBit = strb.useCasc & cascadeIn;

  always_ff @(posedge clk) begin
    if (clr) begin
      holdWord <= '0;
      shiftReg <= '0;
    end else begin
      if (strb.latchWord) holdWord <= parIn;
      if (strb.loadShift) shiftReg <= holdWord;
      else if (strb.shiftOn) shiftReg <= {cascBit, shiftReg[WORD_W-1:1]};
    end
  end

  assign serBit = shiftReg[0];

  // R1: captured word equals the parallel input at the capture edge
  a_r1_latch: assert property (@(posedge clk) disable iff (rst)
    strb.latchWord |=> (holdWord == $past(parIn)));

  // R2: bit 0 of the captured word is on the output right after the load
  a_r2_bit0_slot: assert property (@(posedge clk) disable iff (rst)
    (strb.loadShift && enable) |=> (serBit == $past(holdWord[0])));

  // R5/R9: with cascade off, the shifter top fills with 0
  a_r5_casc_ignored: assert property (@(posedge clk) disable iff (rst)
    (enable && strb.shiftOn && !strb.loadShift && !strb.useCasc) |=> !shiftReg[WORD_W-1]);

endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import fser_pkg::*;
#(
  parameter int WORD_W  = 10,
  parameter int RATIO_W = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               enable,
  input  logic               frameClkEn,
  input  logic               cascadeEn,
  input  logic [RATIO_W-1:0] ratio,
  input  logic               frameRef,
  input  logic [WORD_W-1:0]  parIn,
  input  logic               cascadeIn,
  output logic               serOut,
  output logic               serValid,
  output logic               frameClkOut,
  output logic               frameClkValid
);

  serStrobes_t strb;
  logic        frameClk;

  fser_ctrl #(.WORD_W(WORD_W), .RATIO_W(RATIO_W)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .frameRef(frameRef),
    .cascadeEn(cascadeEn), .ratio(ratio), .strb(strb), .frameClk(frameClk)
  );

  fser_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk(clk), .rst(rst), .enable(enable), .strb(strb),
    .parIn(parIn), .cascadeIn(cascadeIn), .serBit(serOut)
  );

  assign serValid      = enable;
  assign frameClkValid = enable & frameClkEn;
  assign frameClkOut   = frameClk & frameClkEn;

  // R7: one edge after the enable is low, both outputs are quiet
  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!serOut && !frameClk));

endmodule

// File: tb/frame_serializer_tb.sv
`timescale 1ns/1ps
module frame_serializer_tb;

  logic       clk = 1'b0;
  logic       rst;
  logic       enable, frameClkEn, cascadeEn, frameRef, cascadeIn;
  logic [6:0] ratio;
  logic [9:0] parIn;
  logic       serOut, serValid, frameClkOut, frameClkValid;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  frame_serializer u_dut (
    .clk(clk), .rst(rst), .enable(enable), .frameClkEn(frameClkEn),
    .cascadeEn(cascadeEn), .ratio(ratio), .frameRef(frameRef), .parIn(parIn),
    .cascadeIn(cascadeIn), .serOut(serOut), .serValid(serValid),
    .frameClkOut(frameClkOut), .frameClkValid(frameClkValid)
  );

  localparam int NV = 8;
  localparam int          vM   [NV] = '{4, 10, 7, 2, 16, 24, 13, 64};
  localparam logic [9:0]  vW   [NV] = '{10'h005, 10'h2A5, 10'h3FF, 10'h002,
                                        10'h155, 10'h3C3, 10'h0F1, 10'h1B6};
  localparam logic [63:0] vC   [NV] = '{64'hFFFF, 64'hFFFF, 64'hFFFF, 64'h0,
                                        64'h2D, 64'h3FFF, 64'h5,
                                        64'h00A5_F00F_3C96_5AC3};
  localparam bit          vCen [NV] = '{1, 1, 1, 1, 1, 0, 1, 1};
  localparam bit          vFen [NV] = '{1, 1, 1, 1, 1, 1, 0, 1};

  int          prevM;
  logic [9:0]  prevW;
  logic [63:0] prevC;
  bit          prevCen;

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic expBit(input logic [9:0] w, input logic [63:0] c,
                                  input int k, input bit cen);
    if (k < 10) return w[k];
    return cen ? c[k-10] : 1'b0;
  endfunction

  function automatic string bitTag(input int k, input int m, input bit cen);
    if (k == 0) return "R2";
    if (k >= 10) return cen ? "R6" : "R9";
    return (m <= 10) ? "R5" : "R3";
  endfunction

  // One frame, entered and left at a falling edge
  task automatic runFrame(input int m, input logic [9:0] w, input logic [63:0] c,
                          input bit cen, input bit fen, input bit skipHead);
    ratio = 7'(m); cascadeEn = cen; frameClkEn = fen;
    frameRef = 1'b1; parIn = w; cascadeIn = 1'b0;
    for (int j = 1; j <= m; j++) begin
      @(posedge clk); @(negedge clk);
      if (j == 1) begin frameRef = 1'b0; parIn = ~w; end  // R1: later changes ignored
      if (fen) chk(64'(frameClkOut), 64'(j <= m/2), "R4");
      else begin
        chk(64'(frameClkOut), 64'd0, "R8");
        chk(64'(frameClkValid), 64'd0, "R8");
      end
      if (j >= 3) chk(64'(serOut), 64'(expBit(w, c, j-3, cen)), bitTag(j-3, m, cen));
      else if (!skipHead)
        chk(64'(serOut), 64'(expBit(prevW, prevC, prevM-3+j, prevCen)),
            (prevM == 0) ? "R10" : "R3");
      if (j >= 3 && (j-3) < m-10) cascadeIn = c[j-3];
      else cascadeIn = (m <= 10) ? 1'b1 : 1'b0;  // R5: noise that must be ignored
    end
    prevM = m; prevW = w; prevC = c; prevCen = cen;
  endtask

  initial begin
    rst = 1'b1; enable = 1'b1; frameClkEn = 1'b1; cascadeEn = 1'b1;
    ratio = 7'd16; frameRef = 1'b0; parIn = 10'h3FF; cascadeIn = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R10: quiet after reset even with cascade high and no frame reference
    chk(64'(serOut), 64'd0, "R10");
    chk(64'(frameClkOut), 64'd0, "R10");
    repeat (12) @(negedge clk);
    chk(64'(serOut), 64'd0, "R10");
    chk(64'(frameClkOut), 64'd0, "R10");
    chk(64'(serValid), 64'd1, "R7");
    prevM = 0; prevW = '0; prevC = '0; prevCen = 1'b0;

    for (int v = 0; v < NV; v++)
      for (int f = 0; f < 2; f++)
        runFrame(vM[v], vW[v], vC[v], vCen[v], vFen[v], (f == 0) && (v != 0));

    // R7: disable clears everything and hides both outputs
    frameClkEn = 1'b1;
    enable = 1'b0;
    frameRef = 1'b1;
    repeat (2) @(negedge clk);
    frameRef = 1'b0;
    repeat (3) @(negedge clk);
    chk(64'(serValid), 64'd0, "R7");
    chk(64'(frameClkValid), 64'd0, "R7");
    chk(64'(serOut), 64'd0, "R7");
    chk(64'(frameClkOut), 64'd0, "R7");
    enable = 1'b1;
    @(negedge clk);
    chk(64'(serValid), 64'd1, "R7");
    chk(64'(frameClkValid), 64'd1, "R8");
    prevM = 0; prevW = '0; prevC = '0; prevCen = 1'b0;
    runFrame(12, 10'h29B, 64'h3, 1'b1, 1'b1, 1'b0);
    runFrame(12, 10'h064, 64'h2, 1'b1, 1'b1, 1'b0);
    runFrame(5, 10'h013, 64'h0, 1'b1, 1'b1, 1'b1);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule